// File: doc/BRIEF.md
# Pager Batch Frame Synchronizer

This block takes the recovered serial data of a paging channel, one bit per clock on which `bit_en` is high, with the most significant bit of each 32-bit code-word arriving first. It first waits for a run of alternating ones and zeros. It then searches every bit position for the batch sync pattern. Once a sync word is found, the block counts bit positions inside the batch. A batch is one sync word followed by sixteen code-words, which form eight frames of two slots each.

Each code-word that completes is placed on a valid/ready output. It carries its frame number, its slot within the frame, and a flag that is set when the code-word is a message word (first bit 1) and clear when it is an address word (first bit 0). Sync words are never forwarded.

Frame and slot numbers come from position alone. A message that runs past a frame or batch boundary therefore changes nothing in the counting. The sync checker still samples every 17th word. Lock is kept while sync words stay close to the pattern. Lock is dropped after a set number of consecutive bad sync words, and the block then searches for the sync pattern again.

The output has one holding register. `cw_valid` stays high with the word stable until `cw_ready` is seen high at a clock edge. If the next code-word completes before the held one is taken, the newer word replaces it. A consumer must therefore accept each word within 32 bit enables.

Top module: `pager_batch_sync`

## Requirements
- R1: Out of reset `locked` and `cw_valid` are 0.
- R2: Sync search begins only after 32 consecutive alternating bits have been received. A sync word that is not preceded by such a run does not set `locked`.
- R3: While searching, `locked` goes to 1 on the clock after the `bit_en` whose bit completes a 32-bit window that differs from 0x7CD215D8 in at most 2 bit positions. A window with 3 differing bits does not lock.
- R4: While locked, each of the 16 code-words after a sync word sets `cw_valid` on the clock after the `bit_en` carrying its 32nd bit. The first bit received appears in `cw_data[31]`.
- R5: The k-th code-word after a sync word (k = 0..15) is reported with `cw_frame` = k/2 and `cw_slot` = k mod 2, whatever its content.
- R6: `cw_is_msg` is 1 for a code-word whose first received bit is 1 (message word) and 0 for one whose first bit is 0 (address word).
- R7: The word at each sync position, every 17th word (544 bits) after acquisition, never produces `cw_valid`. Exactly 16 words are presented per batch.
- R8: Message words that run across a batch boundary do not shift the sync position. The first word after each sync word is reported as frame 0, slot 0.
- R9: While locked, a sync-position word within 2 bit errors of the pattern keeps lock and clears the miss count. A single failing sync word does not drop lock.
- R10: Two consecutive failing sync-position words clear `locked` on the clock after the 32nd bit of the second one. A following sync word then re-locks without a new preamble.
- R11: While `cw_valid` is 1 and `cw_ready` is 0, data and tags hold until the next code-word completes, which replaces them. `cw_valid` falls after a clock edge with `cw_ready` high and no new word.
- R12: Clocks with `bit_en` low advance nothing: `locked`, the bit position and the word counter keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` for one clock |
| bit_in | input | 1 | Received data bit, MSB of each word first |
| locked | output | 1 | Batch sync is held |
| cw_valid | output | 1 | A code-word is presented |
| cw_ready | input | 1 | Consumer accepts the presented word |
| cw_data | output | 32 | Code-word, first received bit in bit 31 |
| cw_frame | output | 3 | Frame number 0..7 |
| cw_slot | output | 1 | Slot within the frame |
| cw_is_msg | output | 1 | 1 for a message word, 0 for an address word |

## Verification
The hardest condition to reach is loss of lock. It needs two failing sync words that land exactly 544 bits apart while the block is locked. A bad sync word must also not be counted as a miss when a good one lies between the two. The stimulus builds whole batches bit by bit from a preamble onward. It injects chosen bit-error masks only into the word at the sync position: one error, two errors and three errors. It then sends one bad sync, then a good one, then two bad ones in a row, with idle gaps on `bit_en` inside the batches. Back-pressure is reached by holding `cw_ready` low across two word completions.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam logic [31:0] PBS_SYNC_DEFAULT = 32'h7CD2_15D8;

  typedef enum logic [1:0] {
    ST_PREAMBLE = 2'd0,
    ST_SEARCH   = 2'd1,
    ST_LOCKED   = 2'd2
  } pbs_state_e;
endpackage

// File: rtl/pbs_preamble_det.sv
module pbs_preamble_det #(
  parameter int PRE_LEN = 32,
  localparam int RUN_W = $clog2(PRE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic found
);
  logic [RUN_W-1:0] run_q, run_nxt;
  logic             prev_q;

  always_comb begin
    if (run_q == '0 || bit_in == prev_q) run_nxt = RUN_W'(1);
    else if (run_q == RUN_W'(PRE_LEN))   run_nxt = run_q;
    else                                 run_nxt = run_q + RUN_W'(1);
  end

  assign found = bit_en && (run_nxt >= RUN_W'(PRE_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      prev_q <= 1'b0;
    end else if (bit_en) begin
      run_q  <= run_nxt;
      prev_q <= bit_in;
    end
  end
endmodule

// File: rtl/pbs_sync_corr.sv
module pbs_sync_corr #(
  parameter int W   = 32,
  parameter int TOL = 2,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0] pattern,
  input  logic [W-1:0] window,
  output logic         match
);
  logic [W-1:0]     diff;
  logic [CNT_W-1:0] errs;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_diff
      assign diff[g] = window[g] ^ pattern[g];
    end
  endgenerate

  always_comb begin
    errs = '0;
    for (int i = 0; i < W; i++) errs = errs + CNT_W'(diff[i]);
  end

  assign match = (errs <= CNT_W'(TOL));
endmodule

// File: rtl/pbs_batch_pos.sv
module pbs_batch_pos #(
  parameter int W     = 32,
  parameter int WORDS = 17,
  localparam int BIT_W = $clog2(W),
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  output logic [IDX_W-1:0] word_idx,
  output logic             word_end
);
  logic [BIT_W-1:0] bit_q;

  assign word_end = (bit_q == BIT_W'(W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q    <= '0;
      word_idx <= '0;
    end else if (load) begin
      bit_q    <= '0;
      word_idx <= IDX_W'(1);
    end else if (adv) begin
      if (word_end) begin
        bit_q    <= '0;
        word_idx <= (word_idx == IDX_W'(WORDS - 1)) ? '0 : word_idx + IDX_W'(1);
      end else begin
        bit_q <= bit_q + BIT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pager_batch_sync.sv
module pager_batch_sync
  import pbs_pkg::*;
#(
  parameter int CW_W       = 32,
  parameter int FRAMES     = 8,
  parameter int SLOTS      = 2,
  parameter int PRE_LEN    = 32,
  parameter int SYNC_TOL   = 2,
  parameter int MISS_LIMIT = 2,
  parameter logic [CW_W-1:0] SYNC_PAT = CW_W'(PBS_SYNC_DEFAULT),
  localparam int WORDS   = 1 + FRAMES * SLOTS,
  localparam int IDX_W   = $clog2(WORDS),
  localparam int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int MISS_W  = $clog2(MISS_LIMIT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               bit_in,
  output logic               locked,
  output logic               cw_valid,
  input  logic               cw_ready,
  output logic [CW_W-1:0]    cw_data,
  output logic [FRAME_W-1:0] cw_frame,
  output logic [SLOT_W-1:0]  cw_slot,
  output logic               cw_is_msg
);
  pbs_state_e        state_q;
  logic [CW_W-1:0]   sr_q, sr_nxt;
  logic [MISS_W-1:0] miss_q;
  logic              sync_ok, pre_found;
  logic              acquire, adv, word_end, emit, sync_slot;
  logic [IDX_W-1:0]  word_idx, cw_pos;
  int unsigned       cw_pos_i;

  assign sr_nxt = {sr_q[CW_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n)      sr_q <= '0;
    else if (bit_en) sr_q <= sr_nxt;
  end

  pbs_preamble_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .bit_en(bit_en),
    .bit_in(bit_in),
    .found (pre_found)
  );

  pbs_sync_corr #(.W(CW_W), .TOL(SYNC_TOL)) u_corr (
    .pattern(SYNC_PAT),
    .window (sr_nxt),
    .match  (sync_ok)
  );

  assign acquire = bit_en && (state_q == ST_SEARCH) && sync_ok;
  assign adv     = bit_en && (state_q == ST_LOCKED);

  pbs_batch_pos #(.W(CW_W), .WORDS(WORDS)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (acquire),
    .adv     (adv),
    .word_idx(word_idx),
    .word_end(word_end)
  );

  assign sync_slot = adv && word_end && (word_idx == '0);
  assign emit      = adv && word_end && (word_idx != '0);

  // state machine: preamble hunt, sync search, locked with miss counting
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_PREAMBLE;
      miss_q  <= '0;
    end else if (bit_en) begin
      unique case (state_q)
        ST_PREAMBLE: if (pre_found) state_q <= ST_SEARCH;
        ST_SEARCH: if (sync_ok) begin
          state_q <= ST_LOCKED;
          miss_q  <= '0;
        end
        ST_LOCKED: if (sync_slot) begin
          if (sync_ok) begin
            miss_q <= '0;
          end else if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
            state_q <= ST_SEARCH;
            miss_q  <= '0;
          end else begin
            miss_q <= miss_q + MISS_W'(1);
          end
        end
        default: state_q <= ST_PREAMBLE;
      endcase
    end
  end

  assign locked = (state_q == ST_LOCKED);

  // positional frame/slot derived from word index within the batch
  assign cw_pos   = word_idx - IDX_W'(1);
  assign cw_pos_i = int'(cw_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cw_valid  <= 1'b0;
      cw_data   <= '0;
      cw_frame  <= '0;
      cw_slot   <= '0;
      cw_is_msg <= 1'b0;
    end else if (emit) begin
      cw_valid  <= 1'b1;
      cw_data   <= sr_nxt;
      cw_frame  <= FRAME_W'(cw_pos_i / SLOTS);
      cw_slot   <= SLOT_W'(cw_pos_i % SLOTS);
      cw_is_msg <= sr_nxt[CW_W-1];
    end else if (cw_ready) begin
      cw_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bit_en,
  input logic         locked,
  input logic         cw_valid,
  input logic         cw_ready,
  input logic [W-1:0] cw_data
);
  // R11: held word stays stable while stalled and no bit arrives
  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && !cw_ready && !bit_en |=> cw_valid && $stable(cw_data));

  // R11: accepted word is withdrawn when nothing new completes
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && cw_ready && !bit_en |=> !cw_valid);

  // R12: idle clocks leave lock state untouched
  a_r12_idle_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(locked));

  // R4: a new word is only presented after a bit received while locked
  a_r4_emit_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cw_valid) |-> $past(bit_en) && $past(locked));

  // R3: acquisition happens on a bit
  a_r3_lock_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(bit_en));

  // R10: loss happens on a bit
  a_r10_loss_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(bit_en));
endmodule

bind pager_batch_sync pbs_checker #(.W(CW_W)) u_pbs_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bit_en  (bit_en),
  .locked  (locked),
  .cw_valid(cw_valid),
  .cw_ready(cw_ready),
  .cw_data (cw_data)
);

// File: tb/test_pager_batch_sync.sv
module test_pager_batch_sync;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SYNC = 32'h7CD2_15D8;
  localparam logic [31:0] ERR1 = 32'h0001_0000;
  localparam logic [31:0] ERR2 = 32'h0400_0200;
  localparam logic [31:0] ERR3 = 32'h8000_0011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        bit_in = 1'b0;
  logic        cw_ready = 1'b1;
  logic        locked, cw_valid, cw_slot, cw_is_msg;
  logic [31:0] cw_data;
  logic [2:0]  cw_frame;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pager_batch_sync i_pager_batch_sync (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .locked(locked), .cw_valid(cw_valid), .cw_ready(cw_ready),
    .cw_data(cw_data), .cw_frame(cw_frame), .cw_slot(cw_slot),
    .cw_is_msg(cw_is_msg)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int          m_state = 0;   // 0 hunt, 1 search, 2 locked
  int          m_run = 0;
  logic        m_prev = 1'b0;
  logic [31:0] m_sr = '0;
  int          m_pos = 0;
  int          m_miss = 0;
  logic        m_valid = 1'b0;
  logic [31:0] m_word = '0;
  int          m_frame = 0, m_slot = 0;
  logic        m_msg = 1'b0;

  logic rdy_drv = 1'b1;
  bit   gaps = 1'b0;
  int   bitctr = 0;
  bit   mon_on = 1'b0;
  logic [31:0] q_data[$];
  int          q_frame[$], q_slot[$];
  logic        q_msg[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic en, input logic b, input logic rdy);
    logic [31:0] nsr;
    int d;
    if (m_valid && rdy) m_valid = 1'b0;
    if (en) begin
      nsr = {m_sr[30:0], b};
      d = $countones(nsr ^ SYNC);
      if (m_run == 0 || b == m_prev) m_run = 1;
      else if (m_run < 32) m_run++;
      m_prev = b;
      if (m_state == 0) begin
        if (m_run >= 32) m_state = 1;
      end else if (m_state == 1) begin
        if (d <= 2) begin m_state = 2; m_pos = 32; m_miss = 0; end
      end else begin
        if (m_pos % 32 == 31) begin
          if (m_pos / 32 == 0) begin
            if (d <= 2) m_miss = 0;
            else begin
              m_miss++;
              if (m_miss >= 2) begin m_state = 1; m_miss = 0; end
            end
          end else begin
            m_valid = 1'b1;
            m_word  = nsr;
            m_frame = (m_pos / 32 - 1) / 2;
            m_slot  = (m_pos / 32 - 1) % 2;
            m_msg   = nsr[31];
          end
        end
        m_pos = (m_pos == 543) ? 0 : m_pos + 1;
      end
      m_sr = nsr;
    end
  endtask

  task automatic compare();
    chk(locked === (m_state == 2), "R3", 32'(locked), 32'(m_state == 2));
    chk(cw_valid === m_valid, "R4", 32'(cw_valid), 32'(m_valid));
    if (m_valid) begin
      chk(cw_data === m_word, "R4", cw_data, m_word);
      chk(int'(cw_frame) == m_frame, "R5", 32'(cw_frame), 32'(m_frame));
      chk(int'(cw_slot) == m_slot, "R5", 32'(cw_slot), 32'(m_slot));
      chk(cw_is_msg === m_msg, "R6", 32'(cw_is_msg), 32'(m_msg));
    end
    if (mon_on && cw_valid) begin
      q_data.push_back(cw_data);
      q_frame.push_back(int'(cw_frame));
      q_slot.push_back(int'(cw_slot));
      q_msg.push_back(cw_is_msg);
    end
  endtask

  task automatic tick(input logic en, input logic b);
    @(negedge clk);
    compare();
    bit_en = en; bit_in = b; cw_ready = rdy_drv;
    model_step(en, b, rdy_drv);
  endtask

  task automatic send_bit(input logic b);
    bitctr++;
    if (gaps && (bitctr % 5 == 0)) tick(1'b0, ~b);
    tick(1'b1, b);
  endtask

  task automatic send_bits(input logic [31:0] w, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) send_bit(w[i]);
  endtask

  task automatic send_word(input logic [31:0] w);
    send_bits(w, 31, 0);
  endtask

  function automatic logic [31:0] cw_of(input logic msg, input int k, input int b);
    return {msg, 31'((k + 1) * 32'h0101_0203 + b * 32'h77 + 32'h1234)};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, i[0]);
  endtask

  task automatic clear_q();
    q_data.delete(); q_frame.delete(); q_slot.delete(); q_msg.delete();
  endtask

  task automatic plain_batch(input logic [31:0] sync_mask, input int b);
    send_word(SYNC ^ sync_mask);
    for (int k = 0; k < 16; k++) send_word(cw_of(k[1], k, b));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] wa, wb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(1'b0, 1'b0);
    // R1 reset state
    chk(locked === 1'b0, "R1", 32'(locked), 0);
    chk(cw_valid === 1'b0, "R1", 32'(cw_valid), 0);

    // R2: sync without preamble does not lock
    send_word(SYNC);
    for (int k = 0; k < 3; k++) send_word(cw_of(1'b0, k, 9));
    tick(1'b0, 1'b0);
    chk(locked === 1'b0, "R2", 32'(locked), 0);

    // preamble, then sync with 3 errors then 2 errors
    for (int i = 0; i < 40; i++) send_bit(~i[0]);
    send_word(SYNC ^ ERR3);
    tick(1'b0, 1'b0);
    chk(locked === 1'b0, "R3 three errors", 32'(locked), 0);
    send_word(SYNC ^ ERR2);
    tick(1'b0, 1'b0);
    chk(locked === 1'b1, "R3 two errors", 32'(locked), 1);

    // batch 1: mixed words, gaps on bit_en
    gaps = 1'b1; clear_q(); mon_on = 1'b1;
    for (int k = 0; k < 16; k++) send_word(cw_of(k[0], k, 1));
    send_bits(SYNC, 31, 1);
    idle(3);
    mon_on = 1'b0;
    chk(q_data.size() == 16, "R7 count", 32'(q_data.size()), 16);
    for (int k = 0; k < 16 && k < q_data.size(); k++) begin
      chk(q_data[k] == cw_of(k[0], k, 1), "R4 data", q_data[k], cw_of(k[0], k, 1));
      chk(q_frame[k] == k / 2, "R5 frame", 32'(q_frame[k]), 32'(k / 2));
      chk(q_slot[k] == k % 2, "R5 slot", 32'(q_slot[k]), 32'(k % 2));
      chk(q_msg[k] == k[0], "R6 type", 32'(q_msg[k]), 32'(k[0]));
    end
    send_bits(SYNC, 0, 0);

    // batch 2: all message words across the boundary, long idle mid-batch
    clear_q(); mon_on = 1'b1;
    for (int k = 0; k < 16; k++) begin
      send_word(cw_of(1'b1, k, 2));
      if (k == 7) begin
        idle(50);
        chk(locked === 1'b1, "R12 lock", 32'(locked), 1);
        chk(cw_valid === 1'b0, "R12 valid", 32'(cw_valid), 0);
      end
    end
    send_word(SYNC ^ ERR1);
    send_word(cw_of(1'b1, 16, 2));
    idle(2);
    mon_on = 1'b0;
    chk(q_data.size() == 17, "R8 count", 32'(q_data.size()), 17);
    if (q_data.size() == 17) begin
      chk(q_frame[16] == 0 && q_slot[16] == 0, "R8 position", 32'(q_frame[16] * 2 + q_slot[16]), 0);
      chk(q_msg[16] == 1'b1, "R8 type", 32'(q_msg[16]), 1);
    end
    chk(locked === 1'b1, "R9 one error kept", 32'(locked), 1);

    // rest of that batch, with back-pressure on two words
    wa = cw_of(1'b1, 1, 3); wb = cw_of(1'b0, 2, 3);
    rdy_drv = 1'b0;
    send_word(wa);
    tick(1'b0, 1'b0);
    chk(cw_valid === 1'b1 && cw_data == wa, "R11 held", cw_data, wa);
    send_bits(wb, 31, 28);
    chk(cw_valid === 1'b1 && cw_data == wa, "R11 stable", cw_data, wa);
    send_bits(wb, 27, 0);
    tick(1'b0, 1'b0);
    chk(cw_data == wb && cw_frame == 3'd1, "R11 replaced", cw_data, wb);
    rdy_drv = 1'b1;
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    chk(cw_valid === 1'b0, "R11 released", 32'(cw_valid), 0);
    for (int k = 3; k < 16; k++) send_word(cw_of(1'b1, k, 3));

    // R9: one failing sync keeps lock, then good, then one more bad
    plain_batch(ERR3, 4);
    chk(locked === 1'b1, "R9 single miss", 32'(locked), 1);
    plain_batch(32'h0, 5);
    plain_batch(ERR3, 6);
    chk(locked === 1'b1, "R9 miss cleared", 32'(locked), 1);

    // R10: second consecutive failure drops lock
    send_word(SYNC ^ ERR3);
    tick(1'b0, 1'b0);
    chk(locked === 1'b0, "R10 loss", 32'(locked), 0);
    send_word(cw_of(1'b1, 0, 7));
    send_word(SYNC);
    tick(1'b0, 1'b0);
    chk(locked === 1'b1, "R10 relock", 32'(locked), 1);
    for (int k = 0; k < 4; k++) send_word(cw_of(1'b0, k, 8));
    idle(4);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule